// File: doc/BRIEF.md
# Host Controller Bring-up Sequencer

This block is a hardware state machine that takes one USB host controller and its PHY from power-on to a working state, so no firmware routine has to do it. After a start pulse it walks a fixed list of steps. Each step is a 32-bit register write, a read-modify-write that sets or clears one bit, a timed wait, or a handshake with a separate PHY-tuning port. All register traffic goes out on a simple master interface with request, write enable, address, write data, ready and read data.

The list has two reset waves. In the first, the PHY control words are written with the PHY reset held asserted. The block then waits and releases that reset by clearing one bit. In the second, the controller configuration words are written with the controller and PHY soft resets asserted. After another wait the block releases those three resets by clearing one bit each. Only after both waves does it ask the tuning port to run. Waits count a one-cycle microsecond tick, so their length does not depend on the clock frequency. All register addresses and configuration words are parameters. A done pulse marks the end of the list. An error flag records a timeout reported by the tuning port.

Top module: `ctrl_bringup_seq`

## Requirements
- R1: The first transaction is a read of the select register at `SEL_ADDR`. It is followed by a write of the value read with bit `HOST_SEL` set and every other bit unchanged.
- R2: The PHY is configured next, in this order: the SuperSpeed PHY control word `SSPHY_CTRL_VAL` with bit 7 set, the high-speed PHY word `HSPHY_CTRL_VAL`, the SuperSpeed parameter word `SSPHY_PARAM_VAL`, and the general configuration word `GEN_CFG_VAL` with bit 2 set.
- R3: After the PHY writes, at least `WAIT_US` ticks and at most one more pass before the next transaction. That transaction reads the SuperSpeed PHY control register and writes back the value read with only bit 7 cleared.
- R4: The controller writes follow, in this order: pipe control `PIPE_CTRL_VAL` with bit 31 set, USB2 PHY configuration `U2_CFG_VAL` with bit 31 set, global control `GCTL_VAL` with bit 11 set, and user control `UCTL_VAL`.
- R5: After those writes, at least `WAIT_US` ticks and at most one more pass. The block then does three read-modify-writes that clear one bit each, in this order: global control bit 11, USB2 PHY configuration bit 31, pipe control bit 31. Every other bit keeps the value that was read.
- R6: `tune_req` rises only after all 18 bus transactions have finished. It is never high together with `bus_req`. It stays high until `tune_done` is seen.
- R7: `seq_done` is high for exactly one cycle, after `tune_done` has been seen. At that time `bus_req` and `tune_req` are low.
- R8: `seq_err` goes high if `tune_timeout` is high in the cycle where `tune_done` is accepted. It then holds until the next accepted start, which clears it.
- R9: A `start` pulse while a sequence is running has no effect. The run still makes exactly 18 transactions and one done pulse.
- R10: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R11: During and straight after reset, `bus_req`, `tune_req`, `seq_done` and `seq_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a sequence when idle |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transaction accepted this cycle; read data valid |
| bus_rdata | input | 32 | Read data |
| tune_req | output | 1 | Request to the PHY-tuning port |
| tune_done | input | 1 | Tuning port finished |
| tune_timeout | input | 1 | Tuning port timed out; valid with tune_done |
| seq_done | output | 1 | One-cycle pulse at the end of the sequence |
| seq_err | output | 1 | Latched tuning timeout |

## Verification
A wrong step index or a wrong step decode shows up at the bus as a wrong address, wrong data or a missing transaction. The recorded trace catches it at the first transaction that goes wrong. A wrong read-modify-write mask shows in the data of the write that follows its read. A bad wait counter changes the number of ticks between two particular transactions. A broken state machine is caught in one of two ways: the trace length is wrong, or `tune_req` and `seq_done` appear before the trace is complete.

// File: rtl/bringup_pkg.sv
package bringup_pkg;
    localparam int STEP_W = 5;
    localparam int DW     = 32;

    // bit positions whose meaning the controller and PHY decode
    localparam int PHY_SS_RST_BIT  = 7;
    localparam int GEN_XHCI_BIT    = 2;
    localparam int CORE_SRST_BIT   = 11;
    localparam int PHY_SOFT_RST_BIT = 31;

    typedef enum logic [2:0] {
        OP_WR, OP_SET, OP_CLR, OP_WAIT, OP_TUNE, OP_END
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXEC, ST_BUSW, ST_BUSR, ST_WAIT, ST_TUNE
    } st_e;
endpackage

// File: rtl/bringup_us_timer.sv
module bringup_us_timer #(
    parameter int unsigned WAIT_US = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(WAIT_US + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CW'(WAIT_US));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && !expired)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bringup_step_rom.sv
module bringup_step_rom
    import bringup_pkg::*;
#(
    parameter int          AW              = 32,
    parameter int          HOST_SEL        = 0,
    parameter logic [AW-1:0] SEL_ADDR      = '0,
    parameter logic [AW-1:0] SSPHY_CTRL_ADDR = '0,
    parameter logic [AW-1:0] HSPHY_CTRL_ADDR = '0,
    parameter logic [AW-1:0] SSPHY_PARAM_ADDR = '0,
    parameter logic [AW-1:0] GEN_CFG_ADDR  = '0,
    parameter logic [AW-1:0] PIPE_CTRL_ADDR = '0,
    parameter logic [AW-1:0] U2_CFG_ADDR   = '0,
    parameter logic [AW-1:0] GCTL_ADDR     = '0,
    parameter logic [AW-1:0] UCTL_ADDR     = '0,
    parameter logic [DW-1:0] SSPHY_CTRL_VAL = '0,
    parameter logic [DW-1:0] HSPHY_CTRL_VAL = '0,
    parameter logic [DW-1:0] SSPHY_PARAM_VAL = '0,
    parameter logic [DW-1:0] GEN_CFG_VAL   = '0,
    parameter logic [DW-1:0] PIPE_CTRL_VAL = '0,
    parameter logic [DW-1:0] U2_CFG_VAL    = '0,
    parameter logic [DW-1:0] GCTL_VAL      = '0,
    parameter logic [DW-1:0] UCTL_VAL      = '0
) (
    input  logic [STEP_W-1:0] step,
    output op_e               op,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     data
);
    localparam logic [DW-1:0] ONE       = DW'(1);
    localparam logic [DW-1:0] M_SEL     = ONE << HOST_SEL;
    localparam logic [DW-1:0] M_SS_RST  = ONE << PHY_SS_RST_BIT;
    localparam logic [DW-1:0] M_GEN     = ONE << GEN_XHCI_BIT;
    localparam logic [DW-1:0] M_CORE    = ONE << CORE_SRST_BIT;
    localparam logic [DW-1:0] M_PHYSRST = ONE << PHY_SOFT_RST_BIT;

    always_comb begin
        op   = OP_END;
        addr = '0;
        data = '0;
        case (step)
            // controller select
            5'd0:  begin op = OP_SET;  addr = SEL_ADDR;         data = M_SEL; end
            // PHY wave
            5'd1:  begin op = OP_WR;   addr = SSPHY_CTRL_ADDR;  data = SSPHY_CTRL_VAL | M_SS_RST; end
            5'd2:  begin op = OP_WR;   addr = HSPHY_CTRL_ADDR;  data = HSPHY_CTRL_VAL; end
            5'd3:  begin op = OP_WR;   addr = SSPHY_PARAM_ADDR; data = SSPHY_PARAM_VAL; end
            5'd4:  begin op = OP_WR;   addr = GEN_CFG_ADDR;     data = GEN_CFG_VAL | M_GEN; end
            5'd5:  begin op = OP_WAIT; end
            5'd6:  begin op = OP_CLR;  addr = SSPHY_CTRL_ADDR;  data = M_SS_RST; end
            // controller wave
            5'd7:  begin op = OP_WR;   addr = PIPE_CTRL_ADDR;   data = PIPE_CTRL_VAL | M_PHYSRST; end
            5'd8:  begin op = OP_WR;   addr = U2_CFG_ADDR;      data = U2_CFG_VAL | M_PHYSRST; end
            5'd9:  begin op = OP_WR;   addr = GCTL_ADDR;        data = GCTL_VAL | M_CORE; end
            5'd10: begin op = OP_WR;   addr = UCTL_ADDR;        data = UCTL_VAL; end
            5'd11: begin op = OP_WAIT; end
            5'd12: begin op = OP_CLR;  addr = GCTL_ADDR;        data = M_CORE; end
            5'd13: begin op = OP_CLR;  addr = U2_CFG_ADDR;      data = M_PHYSRST; end
            5'd14: begin op = OP_CLR;  addr = PIPE_CTRL_ADDR;   data = M_PHYSRST; end
            // tuning handshake
            5'd15: begin op = OP_TUNE; end
            default: begin op = OP_END; end
        endcase
    end
endmodule

// File: rtl/ctrl_bringup_seq.sv
module ctrl_bringup_seq
    import bringup_pkg::*;
#(
    parameter int          AW              = 32,
    parameter int unsigned WAIT_US         = 5,
    parameter int          HOST_SEL        = 0,
    parameter logic [AW-1:0] SEL_ADDR      = AW'(32'h0000_00b0),
    parameter logic [AW-1:0] SSPHY_CTRL_ADDR = AW'(32'h0000_1030),
    parameter logic [AW-1:0] HSPHY_CTRL_ADDR = AW'(32'h0000_1010),
    parameter logic [AW-1:0] SSPHY_PARAM_ADDR = AW'(32'h0000_1034),
    parameter logic [AW-1:0] GEN_CFG_ADDR  = AW'(32'h0000_1008),
    parameter logic [AW-1:0] PIPE_CTRL_ADDR = AW'(32'h0000_22c0),
    parameter logic [AW-1:0] U2_CFG_ADDR   = AW'(32'h0000_2200),
    parameter logic [AW-1:0] GCTL_ADDR     = AW'(32'h0000_2110),
    parameter logic [AW-1:0] UCTL_ADDR     = AW'(32'h0000_212c),
    parameter logic [DW-1:0] SSPHY_CTRL_VAL = 32'h0100_0119,
    parameter logic [DW-1:0] HSPHY_CTRL_VAL = 32'h0736_0bf2,
    parameter logic [DW-1:0] SSPHY_PARAM_VAL = 32'h06e8_1748,
    parameter logic [DW-1:0] GEN_CFG_VAL   = 32'h0000_0000,
    parameter logic [DW-1:0] PIPE_CTRL_VAL = 32'h030c_0003,
    parameter logic [DW-1:0] U2_CFG_VAL    = 32'h0000_2540,
    parameter logic [DW-1:0] GCTL_VAL      = 32'h0011_1404,
    parameter logic [DW-1:0] UCTL_VAL      = 32'h0c80_8010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          us_tick,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ready,
    input  logic [31:0]   bus_rdata,
    output logic          tune_req,
    input  logic          tune_done,
    input  logic          tune_timeout,
    output logic          seq_done,
    output logic          seq_err
);
    typedef struct packed {
        st_e               st;
        logic [STEP_W-1:0] step;
        logic              req;
        logic              we;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic              set_bit;
        logic              tune;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;

    op_e           step_op;
    logic [AW-1:0] step_addr;
    logic [DW-1:0] step_data;
    logic          timer_clr;
    logic          timer_exp;

    bringup_step_rom #(
        .AW(AW), .HOST_SEL(HOST_SEL),
        .SEL_ADDR(SEL_ADDR), .SSPHY_CTRL_ADDR(SSPHY_CTRL_ADDR),
        .HSPHY_CTRL_ADDR(HSPHY_CTRL_ADDR), .SSPHY_PARAM_ADDR(SSPHY_PARAM_ADDR),
        .GEN_CFG_ADDR(GEN_CFG_ADDR), .PIPE_CTRL_ADDR(PIPE_CTRL_ADDR),
        .U2_CFG_ADDR(U2_CFG_ADDR), .GCTL_ADDR(GCTL_ADDR), .UCTL_ADDR(UCTL_ADDR),
        .SSPHY_CTRL_VAL(SSPHY_CTRL_VAL), .HSPHY_CTRL_VAL(HSPHY_CTRL_VAL),
        .SSPHY_PARAM_VAL(SSPHY_PARAM_VAL), .GEN_CFG_VAL(GEN_CFG_VAL),
        .PIPE_CTRL_VAL(PIPE_CTRL_VAL), .U2_CFG_VAL(U2_CFG_VAL),
        .GCTL_VAL(GCTL_VAL), .UCTL_VAL(UCTL_VAL)
    ) u_rom (
        .step (r_q.step),
        .op   (step_op),
        .addr (step_addr),
        .data (step_data)
    );

    bringup_us_timer #(.WAIT_US(WAIT_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timer_clr),
        .tick    (us_tick),
        .expired (timer_exp)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        timer_clr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_EXEC;
                    r_d.step = '0;
                    r_d.err  = 1'b0;
                end
            end
            ST_EXEC: begin
                case (step_op)
                    OP_WR: begin
                        r_d.req   = 1'b1;
                        r_d.we    = 1'b1;
                        r_d.addr  = step_addr;
                        r_d.wdata = step_data;
                        r_d.st    = ST_BUSW;
                    end
                    OP_SET, OP_CLR: begin
                        r_d.req     = 1'b1;
                        r_d.we      = 1'b0;
                        r_d.addr    = step_addr;
                        r_d.wdata   = step_data;
                        r_d.set_bit = (step_op == OP_SET);
                        r_d.st      = ST_BUSR;
                    end
                    OP_WAIT: begin
                        timer_clr = 1'b1;
                        r_d.st    = ST_WAIT;
                    end
                    OP_TUNE: begin
                        r_d.tune = 1'b1;
                        r_d.st   = ST_TUNE;
                    end
                    default: begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                endcase
            end
            ST_BUSR: begin
                if (bus_ready) begin
                    r_d.we    = 1'b1;
                    r_d.wdata = r_q.set_bit ? (bus_rdata | r_q.wdata)
                                            : (bus_rdata & ~r_q.wdata);
                    r_d.st    = ST_BUSW;
                end
            end
            ST_BUSW: begin
                if (bus_ready) begin
                    r_d.req  = 1'b0;
                    r_d.we   = 1'b0;
                    r_d.step = r_q.step + STEP_W'(1);
                    r_d.st   = ST_EXEC;
                end
            end
            ST_WAIT: begin
                if (timer_exp) begin
                    r_d.step = r_q.step + STEP_W'(1);
                    r_d.st   = ST_EXEC;
                end
            end
            ST_TUNE: begin
                if (tune_done) begin
                    r_d.tune = 1'b0;
                    r_d.err  = tune_timeout;
                    r_d.step = r_q.step + STEP_W'(1);
                    r_d.st   = ST_EXEC;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, step: '0, req: 1'b0, we: 1'b0, addr: '0,
                     wdata: '0, set_bit: 1'b0, tune: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req   = r_q.req;
    assign bus_we    = r_q.we;
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata;
    assign tune_req  = r_q.tune;
    assign seq_done  = r_q.done;
    assign seq_err   = r_q.err;
endmodule

// File: rtl/ctrl_bringup_seq_chk.sv
module ctrl_bringup_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_ready,
    input logic          tune_req,
    input logic          tune_done,
    input logic          tune_timeout,
    input logic          seq_done,
    input logic          seq_err
);
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we)
                                     && $stable(bus_addr) && $stable(bus_wdata)));

    assert_tune_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tune_req && bus_req));

    assert_tune_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_req && !tune_done) |=> tune_req);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!bus_req && !tune_req));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(tune_done && tune_timeout));
endmodule

bind ctrl_bringup_seq ctrl_bringup_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ready    (bus_ready),
    .tune_req     (tune_req),
    .tune_done    (tune_done),
    .tune_timeout (tune_timeout),
    .seq_done     (seq_done),
    .seq_err      (seq_err)
);

// File: tb/ctrl_bringup_seq_test.sv
module ctrl_bringup_seq_test;
    localparam int WAIT_US = 5;
    localparam int HOST    = 1;
    localparam logic [31:0] A_SEL = 32'h0000_00b0, A_SSC = 32'h0000_0130,
        A_HS = 32'h0000_0110, A_SSP = 32'h0000_0134, A_GEN = 32'h0000_0108,
        A_PIPE = 32'h0000_03c0, A_U2 = 32'h0000_0300, A_GCTL = 32'h0000_0210,
        A_UCTL = 32'h0000_022c;
    localparam logic [31:0] V_SSC = 32'h0100_0119, V_HS = 32'h07a6_03b2,
        V_SSP = 32'h06e8_1748, V_GEN = 32'h0000_0000, V_PIPE = 32'h0304_0003,
        V_U2 = 32'h0000_2540, V_GCTL = 32'h0011_1404, V_UCTL = 32'h0c80_8010;
    localparam logic [31:0] SEL_INIT = 32'h0000_0104;
    localparam int NTR = 18;

    // {we, addr, data}; for reads data is the value returned
    localparam logic [64:0] EXP [NTR] = '{
        {1'b0, A_SEL,  SEL_INIT},                         // R1
        {1'b1, A_SEL,  SEL_INIT | (32'd1 << HOST)},       // R1
        {1'b1, A_SSC,  V_SSC | 32'h80},                   // R2
        {1'b1, A_HS,   V_HS},
        {1'b1, A_SSP,  V_SSP},
        {1'b1, A_GEN,  V_GEN | 32'h4},
        {1'b0, A_SSC,  V_SSC | 32'h80},                   // R3
        {1'b1, A_SSC,  V_SSC},
        {1'b1, A_PIPE, V_PIPE | 32'h8000_0000},           // R4
        {1'b1, A_U2,   V_U2 | 32'h8000_0000},
        {1'b1, A_GCTL, V_GCTL | 32'h800},
        {1'b1, A_UCTL, V_UCTL},
        {1'b0, A_GCTL, V_GCTL | 32'h800},                 // R5
        {1'b1, A_GCTL, V_GCTL},
        {1'b0, A_U2,   V_U2 | 32'h8000_0000},
        {1'b1, A_U2,   V_U2},
        {1'b0, A_PIPE, V_PIPE | 32'h8000_0000},
        {1'b1, A_PIPE, V_PIPE}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0;
    logic bus_req, bus_we, bus_ready = 1'b0, tune_req, tune_done = 1'b0;
    logic tune_timeout = 1'b0, seq_done, seq_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

    always #5 clk = ~clk;

    ctrl_bringup_seq #(
        .AW(32), .WAIT_US(WAIT_US), .HOST_SEL(HOST),
        .SEL_ADDR(A_SEL), .SSPHY_CTRL_ADDR(A_SSC), .HSPHY_CTRL_ADDR(A_HS),
        .SSPHY_PARAM_ADDR(A_SSP), .GEN_CFG_ADDR(A_GEN), .PIPE_CTRL_ADDR(A_PIPE),
        .U2_CFG_ADDR(A_U2), .GCTL_ADDR(A_GCTL), .UCTL_ADDR(A_UCTL),
        .SSPHY_CTRL_VAL(V_SSC), .HSPHY_CTRL_VAL(V_HS), .SSPHY_PARAM_VAL(V_SSP),
        .GEN_CFG_VAL(V_GEN), .PIPE_CTRL_VAL(V_PIPE), .U2_CFG_VAL(V_U2),
        .GCTL_VAL(V_GCTL), .UCTL_VAL(V_UCTL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .tune_req(tune_req), .tune_done(tune_done), .tune_timeout(tune_timeout),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    int checks = 0, fails = 0;

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register file model behind the bus
    logic [31:0] mem [10];
    function automatic int ridx(input logic [31:0] a);
        case (a)
            A_SEL: return 0;  A_SSC: return 1;  A_HS: return 2;
            A_SSP: return 3;  A_GEN: return 4;  A_PIPE: return 5;
            A_U2: return 6;   A_GCTL: return 7; A_UCTL: return 8;
            default: return 9;
        endcase
    endfunction

    logic [64:0] trace [64];
    int tick_at [64];
    int tcount = 0, wcnt = 0, tick_total = 0, tdiv = 0;
    int done_cnt = 0, tdone_cnt = 0, tdel = 0;
    bit tune_early = 0, done_early = 0;

    initial begin
        for (int i = 0; i < 10; i++) mem[i] = '0;
        mem[0] = SEL_INIT;
    end

    // bus slave: variable latency, ready for one cycle per transaction
    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready <= 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= (tcount % 3)) begin
                bus_ready <= 1'b1;
                tick_at[tcount] = tick_total;
                if (bus_we) begin
                    mem[ridx(bus_addr)] = bus_wdata;
                    trace[tcount] = {1'b1, bus_addr, bus_wdata};
                end else begin
                    bus_rdata <= mem[ridx(bus_addr)];
                    trace[tcount] = {1'b0, bus_addr, mem[ridx(bus_addr)]};
                end
                tcount = tcount + 1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    // microsecond tick every 10 cycles
    always @(negedge clk) begin
        if (us_tick) tick_total = tick_total + 1;
        tdiv = (tdiv == 9) ? 0 : tdiv + 1;
        us_tick <= (tdiv == 9);
    end

    // tuning port responder and output monitors
    always @(negedge clk) begin
        if (tune_done) begin
            tune_done <= 1'b0;
        end else if (tune_req) begin
            if (tcount % NTR != 0) tune_early = 1;
            tdel = tdel + 1;
            if (tdel == 6) begin
                tune_done <= 1'b1;
                tdone_cnt = tdone_cnt + 1;
                tdel = 0;
            end
        end
        if (seq_done) begin
            done_cnt = done_cnt + 1;
            if (tdone_cnt != done_cnt) done_early = 1;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 bus_req in reset", 65'(bus_req), 65'(0));
        chk("R11 tune_req in reset", 65'(tune_req), 65'(0));
        chk("R11 seq_done/seq_err in reset", 65'({seq_done, seq_err}), 65'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 idle after reset", 65'({bus_req, tune_req, seq_done, seq_err}), 65'(0));

        // run 1: full trace, with a stray start mid-run
        pulse_start();
        wait (tcount == 3);
        pulse_start();                       // R9 must be ignored
        wait (done_cnt == 1);
        repeat (20) @(negedge clk);
        for (int i = 0; i < NTR; i++)
            chk($sformatf("R1-5 trace entry %0d", i), trace[i], EXP[i]);
        chk("R9 transaction count", 65'(tcount), 65'(NTR));
        chk("R9/R7 single done pulse", 65'(done_cnt), 65'(1));
        chk("R3 wait length lower", 65'((tick_at[6] - tick_at[5]) >= WAIT_US), 65'(1));
        chk("R3 wait length upper", 65'((tick_at[6] - tick_at[5]) <= WAIT_US + 1), 65'(1));
        chk("R5 wait length lower", 65'((tick_at[12] - tick_at[11]) >= WAIT_US), 65'(1));
        chk("R5 wait length upper", 65'((tick_at[12] - tick_at[11]) <= WAIT_US + 1), 65'(1));
        chk("R6 tune only after bus traffic", 65'(tune_early), 65'(0));
        chk("R7 done only after tune_done", 65'(done_early), 65'(0));
        chk("R8 no error without timeout", 65'(seq_err), 65'(0));

        // run 2: tuning reports a timeout
        tune_timeout = 1'b1;
        pulse_start();
        wait (done_cnt == 2);
        @(negedge clk);
        tune_timeout = 1'b0;
        chk("R8 error latched", 65'(seq_err), 65'(1));
        chk("R1 select bits kept on rerun", trace[NTR + 1],
            {1'b1, A_SEL, SEL_INIT | (32'd1 << HOST)});
        chk("R9 second run count", 65'(tcount), 65'(2 * NTR));
        repeat (5) @(negedge clk);
        chk("R8 error holds while idle", 65'(seq_err), 65'(1));

        // run 3: start clears the error
        pulse_start();
        @(negedge clk);
        chk("R8 error cleared by start", 65'(seq_err), 65'(0));
        wait (done_cnt == 3);
        @(negedge clk);
        chk("R8 clean third run", 65'(seq_err), 65'(0));
        chk("R6/R7 third run ordering", 65'({tune_early, done_early}), 65'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule